// File: doc/BRIEF.md
# Paired-Page Translation Lookup Unit

This block is a small, fully associative address translation buffer. Each entry describes two neighbouring virtual pages at once, an even page and an odd page, and holds a separate physical frame, valid bit and writable bit for each of them. A per-entry page mask widens the page size beyond the minimum, so one tag can cover a pair of large pages.

A request presents a 32-bit virtual address, the current 8-bit address space identifier and a write flag. One cycle later the unit returns a registered response. The response carries a result code, the physical address and a write-permission flag. The possible results are a successful match, no matching entry, a hit on a page that is not valid, or a write to a page that is not writable.

Entries are loaded through an index/data write port. The surrounding logic owns replacement and refill.

Top module: `tlb_pair_lookup`

## Requirements
- R1: `rsp_valid` is high in exactly the cycle after a cycle with `req_valid` high, and the response fields describe that request. A synchronous active-low reset clears `rsp_valid`, `rsp_code`, `rsp_paddr` and `rsp_wr_ok` to zero, and clears every entry field to zero.
- R2: An entry hits when its global bit is set or its stored identifier equals `req_asid`, and `req_vaddr & ~E` equals `vpn & ~E`. Here E is the entry's effective mask.
- R3: The effective mask is E = `pmask | (2^(MIN_PAGE_BITS+1) - 1)`, with MIN_PAGE_BITS = 12 by default. `pmask` is assumed to be a run of ones that starts at bit MIN_PAGE_BITS+1. With `pmask` = 0 the pages are 4 KB. With `pmask` = 0x6000 the pages are 16 KB.
- R4: The half is chosen by the bit of `req_vaddr` at the highest set bit of E. A 0 selects the even fields (`pfn0`, `v0`, `d0`). A 1 selects the odd fields (`pfn1`, `v1`, `d1`).
- R5: On a hit whose selected valid bit is 0, the code is INVALID (2'd2) for reads and for writes alike.
- R6: On a write hit whose selected valid bit is 1 and selected writable bit is 0, the code is DIRTY (2'd3).
- R7: On success the code is MATCH (2'd0). `rsp_paddr` is the selected frame ORed with `req_vaddr & (E >> 1)`. `rsp_wr_ok` equals the selected writable bit, so a read of a non-writable page still matches, with `rsp_wr_ok` = 0.
- R8: When no entry hits, the code is NOMATCH (2'd1).
- R9: Whenever the code is not MATCH, `rsp_paddr` is 0 and `rsp_wr_ok` is 0.
- R10: When several entries hit, the lowest index supplies the result.
- R11: A write to an entry is seen by lookups issued in a later cycle. A lookup issued in the same cycle as the write sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Load entry `wr_idx` with the write fields |
| wr_idx | input | 3 | Entry index to load |
| wr_vpn | input | 32 | Virtual tag, in address form |
| wr_pmask | input | 32 | Page-size mask above the minimum pair span |
| wr_asid | input | 8 | Stored address space identifier |
| wr_global | input | 1 | Ignore the identifier when matching |
| wr_pfn0 | input | 32 | Even page frame, in address form |
| wr_pfn1 | input | 32 | Odd page frame, in address form |
| wr_v0 | input | 1 | Even page valid |
| wr_v1 | input | 1 | Odd page valid |
| wr_d0 | input | 1 | Even page writable |
| wr_d1 | input | 1 | Odd page writable |
| req_valid | input | 1 | Lookup request |
| req_vaddr | input | 32 | Virtual address to translate |
| req_asid | input | 8 | Current address space identifier |
| req_write | input | 1 | Access is a write |
| rsp_valid | output | 1 | Response present |
| rsp_code | output | 2 | 0 match, 1 no match, 2 invalid, 3 dirty |
| rsp_paddr | output | 32 | Translated physical address |
| rsp_wr_ok | output | 1 | Page may be written |

## Verification
The per-cycle properties cover the response timing and the zeroing of address and permission on every failed result. They also check that a DIRTY result only follows a write request, that a successful write is always writable, and that the page offset passes through unchanged. The bench scenarios show the rest:
- hit selection by identifier or global bit;
- even/odd choice at several page sizes;
- the invalid-versus-dirty order;
- lowest-index priority on duplicate tags;
- the visibility of a write made in the same cycle as a lookup.

// File: rtl/tlb_pkg.sv
// Shared widths, entry layout and result codes for the paired-page lookup unit.
// Assumes a single address width for virtual and physical addresses.
package tlb_pkg;
    parameter int TLB_VA_W   = 32;
    parameter int TLB_ASID_W = 8;

    typedef enum logic [1:0] {
        RES_MATCH   = 2'd0,
        RES_NOMATCH = 2'd1,
        RES_INVALID = 2'd2,
        RES_DIRTY   = 2'd3
    } tlb_res_e;

    typedef struct packed {
        logic [TLB_VA_W-1:0]   vpn;
        logic [TLB_VA_W-1:0]   pmask;
        logic [TLB_VA_W-1:0]   pfn0;
        logic [TLB_VA_W-1:0]   pfn1;
        logic [TLB_ASID_W-1:0] asid;
        logic                  glb;
        logic                  v0;
        logic                  v1;
        logic                  d0;
        logic                  d1;
    } tlb_entry_t;
endpackage

// File: rtl/tlb_entry_store.sv
// Register array holding the translation entries.
// Assumes one write per cycle; the new contents become visible after the edge.
module tlb_entry_store
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  tlb_entry_t                   wr_data,
    output tlb_entry_t [NUM_ENTRIES-1:0] ent_q
);
    // Load the indexed entry, or clear the whole array on reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ent_q <= '0;
        end else if (wr_en) begin
            ent_q[wr_idx] <= wr_data;
        end
    end
endmodule

// File: rtl/tlb_tag_cmp.sv
// Compares one entry against a lookup address and identifier.
// It reports a hit, which half of the pair applies, and the offset mask of that half.
// Assumes pmask is a contiguous run of ones starting above the minimum pair span.
module tlb_tag_cmp
    import tlb_pkg::*;
#(
    parameter int MIN_PAGE_BITS = 12
) (
    input  tlb_entry_t              ent,
    input  logic [TLB_VA_W-1:0]     vaddr,
    input  logic [TLB_ASID_W-1:0]   asid,
    output logic                    hit,
    output logic                    odd,
    output logic [TLB_VA_W-1:0]     half_mask
);
    localparam logic [TLB_VA_W-1:0] BASE_MASK =
        {{(TLB_VA_W-MIN_PAGE_BITS-1){1'b0}}, {(MIN_PAGE_BITS+1){1'b1}}};

    logic [TLB_VA_W-1:0] eff_mask;
    logic [TLB_VA_W-1:0] sel_bit;

    // Form the pair mask, find the half-select bit and decide the hit.
    always_comb begin
        eff_mask  = ent.pmask | BASE_MASK;
        half_mask = eff_mask >> 1;
        sel_bit   = eff_mask & ~half_mask;
        odd       = |(vaddr & sel_bit);
        hit       = (ent.glb || (ent.asid == asid)) &&
                    ((vaddr & ~eff_mask) == (ent.vpn & ~eff_mask));
    end
endmodule

// File: rtl/tlb_resolve.sv
// Picks the lowest-index hit and turns its selected half into a result.
// Assumes all per-entry compare outputs are presented together.
module tlb_resolve
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES = 8,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  tlb_entry_t [NUM_ENTRIES-1:0]    ents,
    input  logic [NUM_ENTRIES-1:0]          hits,
    input  logic [NUM_ENTRIES-1:0]          odds,
    input  logic [NUM_ENTRIES-1:0][TLB_VA_W-1:0] halves,
    input  logic [TLB_VA_W-1:0]             vaddr,
    input  logic                            is_write,
    output tlb_res_e                        code,
    output logic [TLB_VA_W-1:0]             paddr,
    output logic                            wr_ok
);
    logic [IDX_W-1:0]    win;
    tlb_entry_t          w_ent;
    logic                w_odd;
    logic                w_valid;
    logic                w_dirty;
    logic [TLB_VA_W-1:0] w_pfn;

    // Priority pick: scanning downward leaves the lowest hitting index.
    always_comb begin
        win = '0;
        for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
            if (hits[i]) win = IDX_W'(i);
        end
    end

    // Select the winning half and classify the access.
    always_comb begin
        w_ent   = ents[win];
        w_odd   = odds[win];
        w_valid = w_odd ? w_ent.v1   : w_ent.v0;
        w_dirty = w_odd ? w_ent.d1   : w_ent.d0;
        w_pfn   = w_odd ? w_ent.pfn1 : w_ent.pfn0;
        code    = RES_NOMATCH;
        paddr   = '0;
        wr_ok   = 1'b0;
        if (|hits) begin
            if (!w_valid) begin
                code = RES_INVALID;
            end else if (is_write && !w_dirty) begin
                code = RES_DIRTY;
            end else begin
                code  = RES_MATCH;
                paddr = w_pfn | (vaddr & halves[win]);
                wr_ok = w_dirty;
            end
        end
    end
endmodule

// File: rtl/tlb_pair_lookup.sv
// Top of the paired-page lookup unit: entry store, compare per entry,
// resolution, and a registered response one cycle after each request.
// Assumes requests may arrive every cycle; the response holds between requests.
module tlb_pair_lookup
    import tlb_pkg::*;
#(
    parameter int NUM_ENTRIES   = 8,
    parameter int MIN_PAGE_BITS = 12,
    localparam int IDX_W = (NUM_ENTRIES > 1) ? $clog2(NUM_ENTRIES) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IDX_W-1:0]      wr_idx,
    input  logic [TLB_VA_W-1:0]   wr_vpn,
    input  logic [TLB_VA_W-1:0]   wr_pmask,
    input  logic [TLB_ASID_W-1:0] wr_asid,
    input  logic                  wr_global,
    input  logic [TLB_VA_W-1:0]   wr_pfn0,
    input  logic [TLB_VA_W-1:0]   wr_pfn1,
    input  logic                  wr_v0,
    input  logic                  wr_v1,
    input  logic                  wr_d0,
    input  logic                  wr_d1,
    input  logic                  req_valid,
    input  logic [TLB_VA_W-1:0]   req_vaddr,
    input  logic [TLB_ASID_W-1:0] req_asid,
    input  logic                  req_write,
    output logic                  rsp_valid,
    output logic [1:0]            rsp_code,
    output logic [TLB_VA_W-1:0]   rsp_paddr,
    output logic                  rsp_wr_ok
);
    tlb_entry_t                           wr_data;
    tlb_entry_t [NUM_ENTRIES-1:0]         ents;
    logic [NUM_ENTRIES-1:0]               hits;
    logic [NUM_ENTRIES-1:0]               odds;
    logic [NUM_ENTRIES-1:0][TLB_VA_W-1:0] halves;
    tlb_res_e                             code_c;
    logic [TLB_VA_W-1:0]                  paddr_c;
    logic                                 wr_ok_c;

    // Gather the write fields into one entry word.
    always_comb begin
        wr_data = '{vpn: wr_vpn, pmask: wr_pmask, pfn0: wr_pfn0, pfn1: wr_pfn1,
                    asid: wr_asid, glb: wr_global, v0: wr_v0, v1: wr_v1,
                    d0: wr_d0, d1: wr_d1};
    end

    tlb_entry_store #(.NUM_ENTRIES(NUM_ENTRIES)) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ent_q   (ents)
    );

    for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_cmp
        tlb_tag_cmp #(.MIN_PAGE_BITS(MIN_PAGE_BITS)) u_cmp (
            .ent       (ents[g]),
            .vaddr     (req_vaddr),
            .asid      (req_asid),
            .hit       (hits[g]),
            .odd       (odds[g]),
            .half_mask (halves[g])
        );
    end

    tlb_resolve #(.NUM_ENTRIES(NUM_ENTRIES)) u_res (
        .ents     (ents),
        .hits     (hits),
        .odds     (odds),
        .halves   (halves),
        .vaddr    (req_vaddr),
        .is_write (req_write),
        .code     (code_c),
        .paddr    (paddr_c),
        .wr_ok    (wr_ok_c)
    );

    // Register the response for each accepted request.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_code  <= '0;
            rsp_paddr <= '0;
            rsp_wr_ok <= 1'b0;
        end else begin
            rsp_valid <= req_valid;
            if (req_valid) begin
                rsp_code  <= code_c;
                rsp_paddr <= paddr_c;
                rsp_wr_ok <= wr_ok_c;
            end
        end
    end
endmodule

// File: rtl/tlb_pair_lookup_checker.sv
// Clocked properties on the lookup unit's ports, bound to every instance.
module tlb_pair_lookup_checker #(
    parameter int VA_W          = 32,
    parameter int MIN_PAGE_BITS = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            req_valid,
    input logic [VA_W-1:0] req_vaddr,
    input logic            req_write,
    input logic            rsp_valid,
    input logic [1:0]      rsp_code,
    input logic [VA_W-1:0] rsp_paddr,
    input logic            rsp_wr_ok
);
    // R1: a request produces a response on the next cycle
    a_r1_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);
    // R1: no response without a request
    a_r1_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> !rsp_valid);
    // R9: failed results carry no address and no write permission
    a_r9_fail_zeroed: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code != 2'd0) |-> (rsp_paddr == '0 && !rsp_wr_ok));
    // R6: a dirty result only answers a write
    a_r6_dirty_on_write: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd3) |-> $past(req_write));
    // R7: a successful write is always writable
    a_r7_write_match_ok: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd0 && $past(req_write)) |-> rsp_wr_ok);
    // R7: the minimum page offset passes straight through
    a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_code == 2'd0) |->
        (rsp_paddr[MIN_PAGE_BITS-1:0] == $past(req_vaddr[MIN_PAGE_BITS-1:0])));
endmodule

bind tlb_pair_lookup tlb_pair_lookup_checker #(
    .VA_W(tlb_pkg::TLB_VA_W), .MIN_PAGE_BITS(MIN_PAGE_BITS)
) u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .req_write(req_write), .rsp_valid(rsp_valid), .rsp_code(rsp_code),
    .rsp_paddr(rsp_paddr), .rsp_wr_ok(rsp_wr_ok)
);

// File: tb/tb_tlb_pair_lookup.sv
// Self-checking bench: directed corners plus seeded random lookups against a model.
module tb_tlb_pair_lookup;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_idx;
    logic [31:0] wr_vpn, wr_pmask, wr_pfn0, wr_pfn1;
    logic [7:0]  wr_asid;
    logic        wr_global, wr_v0, wr_v1, wr_d0, wr_d1;
    logic        req_valid;
    logic [31:0] req_vaddr;
    logic [7:0]  req_asid;
    logic        req_write;
    logic        rsp_valid;
    logic [1:0]  rsp_code;
    logic [31:0] rsp_paddr;
    logic        rsp_wr_ok;

    int n_vec  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [31:0] s_vpn[N], s_pm[N], s_p0[N], s_p1[N];
    logic [7:0]  s_asid[N];
    logic        s_g[N], s_v0[N], s_v1[N], s_d0[N], s_d1[N];

    always #2.5 clk = ~clk;

    tlb_pair_lookup dut (.*);

    // Expected result from the requirements (R2..R10).
    task automatic model(input logic [31:0] va, input logic [7:0] id, input logic w,
                         output logic [1:0] code, output logic [31:0] pa, output logic ok);
        int win = -1;
        code = 2'd1; pa = 32'd0; ok = 1'b0;
        for (int i = N - 1; i >= 0; i--) begin
            logic [31:0] e;
            e = s_pm[i] | 32'h0000_1FFF;
            if ((s_g[i] || s_asid[i] == id) && ((va & ~e) == (s_vpn[i] & ~e))) win = i;
        end
        if (win >= 0) begin
            logic [31:0] e, h;
            logic o, v, d;
            e = s_pm[win] | 32'h0000_1FFF;
            h = e >> 1;
            o = |(va & e & ~h);
            v = o ? s_v1[win] : s_v0[win];
            d = o ? s_d1[win] : s_d0[win];
            if (!v) code = 2'd2;
            else if (w && !d) code = 2'd3;
            else begin
                code = 2'd0;
                pa = (o ? s_p1[win] : s_p0[win]) | (va & h);
                ok = d;
            end
        end
    endtask

    task automatic put(input int idx, input logic [31:0] vpn, pm, p0, p1,
                       input logic [7:0] id, input logic g, v0, v1, d0, d1);
        @(negedge clk);
        wr_en = 1; wr_idx = 3'(idx); wr_vpn = vpn; wr_pmask = pm; wr_pfn0 = p0;
        wr_pfn1 = p1; wr_asid = id; wr_global = g; wr_v0 = v0; wr_v1 = v1;
        wr_d0 = d0; wr_d1 = d1;
        @(negedge clk);
        wr_en = 0;
        s_vpn[idx] = vpn; s_pm[idx] = pm; s_p0[idx] = p0; s_p1[idx] = p1;
        s_asid[idx] = id; s_g[idx] = g; s_v0[idx] = v0; s_v1[idx] = v1;
        s_d0[idx] = d0; s_d1[idx] = d1;
    endtask

    task automatic compare(input string tag, input logic [1:0] ec,
                           input logic [31:0] ep, input logic eo);
        n_vec++;
        if (!rsp_valid || rsp_code !== ec || rsp_paddr !== ep || rsp_wr_ok !== eo) begin
            n_fail++;
            $display("FAIL %s: got v=%0b code=%0d pa=%h ok=%0b, want v=1 code=%0d pa=%h ok=%0b",
                     tag, rsp_valid, rsp_code, rsp_paddr, rsp_wr_ok, ec, ep, eo);
        end
    endtask

    task automatic look(input string tag, input logic [31:0] va, input logic [7:0] id,
                        input logic w);
        logic [1:0] ec; logic [31:0] ep; logic eo;
        model(va, id, w, ec, ep, eo);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_asid = id; req_write = w;
        @(negedge clk);
        req_valid = 0;
        compare(tag, ec, ep, eo);
    endtask

    // Check a fixed expectation alongside the model.
    task automatic look_exp(input string tag, input logic [31:0] va, input logic [7:0] id,
                            input logic w, input logic [1:0] ec, input logic [31:0] ep,
                            input logic eo);
        @(negedge clk);
        req_valid = 1; req_vaddr = va; req_asid = id; req_write = w;
        @(negedge clk);
        req_valid = 0;
        compare(tag, ec, ep, eo);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, want completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
            $finish;
        end
    end

    initial begin
        logic [31:0] sizes[3];
        void'($urandom(32'd4242));
        sizes[0] = 32'h0; sizes[1] = 32'h0000_6000; sizes[2] = 32'h001F_E000;
        rst_n = 0; wr_en = 0; wr_idx = 0; wr_vpn = 0; wr_pmask = 0; wr_pfn0 = 0;
        wr_pfn1 = 0; wr_asid = 0; wr_global = 0; wr_v0 = 0; wr_v1 = 0; wr_d0 = 0;
        wr_d1 = 0; req_valid = 0; req_vaddr = 0; req_asid = 0; req_write = 0;
        for (int i = 0; i < N; i++) begin
            s_vpn[i] = 0; s_pm[i] = 0; s_p0[i] = 0; s_p1[i] = 0; s_asid[i] = 0;
            s_g[i] = 0; s_v0[i] = 0; s_v1[i] = 0; s_d0[i] = 0; s_d1[i] = 0;
        end
        repeat (3) @(negedge clk);
        // R1: reset state
        n_vec++;
        if (rsp_valid !== 0 || rsp_code !== 0 || rsp_paddr !== 0 || rsp_wr_ok !== 0) begin
            n_fail++;
            $display("FAIL R1 reset: got v=%0b code=%0d pa=%h ok=%0b, want all zero",
                     rsp_valid, rsp_code, rsp_paddr, rsp_wr_ok);
        end
        rst_n = 1;
        // R1: cleared entries give an invalid hit at address 0 with identifier 0
        look_exp("R1 cleared entry", 32'h0000_0123, 8'h00, 0, 2'd2, 32'h0, 0);
        for (int i = 0; i < N; i++)
            put(i, 32'hF000_0000 + 32'(i) * 32'h0100_0000, 0, 0, 0, 8'hEE, 0, 0, 0, 0, 0);

        // 4 KB pair at 0x0040_0000, identifier 5
        put(0, 32'h0040_0000, 32'h0, 32'h1234_5000, 32'h0ABC_D000, 8'h05, 0, 1, 1, 1, 0);
        look_exp("R4 even half", 32'h0040_0ABC, 8'h05, 0, 2'd0, 32'h1234_5ABC, 1);
        look_exp("R4 odd half", 32'h0040_1ABC, 8'h05, 0, 2'd0, 32'h0ABC_DABC, 0);
        look_exp("R7 write even ok", 32'h0040_0004, 8'h05, 1, 2'd0, 32'h1234_5004, 1);
        look_exp("R6 write odd dirty", 32'h0040_1004, 8'h05, 1, 2'd3, 32'h0, 0);
        look_exp("R2 R8 asid mismatch", 32'h0040_0004, 8'h06, 0, 2'd1, 32'h0, 0);
        look_exp("R8 tag miss", 32'h0040_2004, 8'h05, 0, 2'd1, 32'h0, 0);
        // 16 KB pair, global, odd half invalid
        put(1, 32'h0100_0000, 32'h0000_6000, 32'h2000_0000, 32'h3000_0000, 8'h00, 1, 1, 0, 1, 1);
        look_exp("R3 16K even offset", 32'h0100_3FFC, 8'h77, 0, 2'd0, 32'h2000_3FFC, 1);
        look_exp("R5 invalid read", 32'h0100_4000, 8'h77, 0, 2'd2, 32'h0, 0);
        look_exp("R5 invalid write", 32'h0100_7000, 8'h01, 1, 2'd2, 32'h0, 0);
        // R10: duplicate tag in a higher slot loses
        put(5, 32'h0040_0000, 32'h0, 32'h5555_5000, 32'h6666_6000, 8'h05, 0, 1, 1, 1, 1);
        look_exp("R10 lowest index", 32'h0040_0010, 8'h05, 0, 2'd0, 32'h1234_5010, 1);
        // R11: a lookup in the same cycle as the write sees old contents
        @(negedge clk);
        wr_en = 1; wr_idx = 0; wr_vpn = 32'h0040_0000; wr_pmask = 0; wr_pfn0 = 32'h7777_7000;
        wr_pfn1 = 32'h0; wr_asid = 8'h05; wr_global = 0; wr_v0 = 1; wr_v1 = 0; wr_d0 = 0; wr_d1 = 0;
        req_valid = 1; req_vaddr = 32'h0040_0020; req_asid = 8'h05; req_write = 0;
        @(negedge clk);
        wr_en = 0; req_valid = 0;
        compare("R11 same-cycle old", 2'd0, 32'h1234_5020, 1);
        s_p0[0] = 32'h7777_7000; s_v1[0] = 0; s_d0[0] = 0; s_p1[0] = 0;
        look_exp("R11 next-cycle new", 32'h0040_0020, 8'h05, 0, 2'd0, 32'h7777_7020, 0);

        // Random phase: R2 R3 R4 R5 R6 R7 R8 R10 against the model
        for (int round = 0; round < 6; round++) begin
            for (int i = 0; i < N; i++) begin
                logic [31:0] pm, h;
                pm = sizes[$urandom_range(2)];
                h  = (pm | 32'h1FFF) >> 1;
                put(i, {$urandom_range(3), 28'h0} | ({$urandom_range(7), 21'h0}),
                    pm, $urandom & ~h, $urandom & ~h, 8'($urandom_range(3)),
                    1'($urandom_range(3) == 0), 1'($urandom), 1'($urandom),
                    1'($urandom), 1'($urandom));
            end
            for (int k = 0; k < 200; k++) begin
                int j;
                logic [31:0] va;
                j  = $urandom_range(N - 1);
                va = (s_vpn[j] & ~(s_pm[j] | 32'h1FFF)) | ($urandom & (s_pm[j] | 32'h1FFF));
                if ($urandom_range(9) == 0) va = $urandom;
                look("R2-random", va, 8'($urandom_range(3)), 1'($urandom));
            end
        end
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
        $finish;
    end
endmodule